// File: doc/BRIEF.md
# Audio Output Source Selector with Muting

This block sits at the output of a digital audio receiver and decides which serial stream reaches the two data outputs. One candidate is the demodulated receiver stream. The other is an auxiliary serial input. Normally the choice follows the lock status of the recovery PLL: locked selects receiver data and unlocked selects the auxiliary stream. A force command selects the auxiliary stream regardless of lock.

Every change of source passes through a muted interval of whole frames. During that interval both outputs are held at logic 0. A 2-bit forced-mute command can silence the outputs at any time, and it overrides every source choice. The block also drives three status outputs: an error flag, a lock indication and a select line that steers the clock source toward the crystal.

The primary data output has a fixed latency of two frames, which counts as zero programmed delay. The secondary pin carries no extra delay. By default it carries the validity flag, and a select input turns it into a copy of the data. Inputs are one bit per clock, and a strobe marks the first bit of each frame.

Top module: `audio_src_sel`

## Requirements
- R1: After the 2-flop synchronizer, lock selects the receiver stream and no lock selects the auxiliary stream. The switch happens with no command.
- R2: While `force_aux` is 1, the auxiliary stream is selected whatever the lock state.
- R3: A change of the wanted source that is seen before the strobe of frame f+1 makes frames f+1 .. f+GAP_FRAMES all-zero (GAP_FRAMES defaults to 2). The new source appears from frame f+1+GAP_FRAMES. The muted state changes only at frame strobes.
- R4: `err_flag` is 0 only while receiver data is being passed with no muting gap. It rises at the strobe that starts a gap or selects the auxiliary stream, and it falls at the strobe where receiver data first passes. It changes only on strobe cycles.
- R5: `lock_ind` is the synchronized lock ANDed with NOT `force_aux`, and it follows with one register of delay. `xtal_sel` is 1 while the current or pending source is the auxiliary stream, and it updates only at frame strobes.
- R6: `mute_code` is sampled at each frame strobe. Codes 2'b01, 2'b10 and 2'b11 make the whole following frame all-zero, and 2'b00 plays. Forced mute overrides both sources and the gap.
- R7: Every output frame is exactly one of three things: the receiver frame, the auxiliary frame or all zeros. No partial frame is emitted.
- R8: With `sec_sel` at 0, `sec_out` equals `rx_valid` two clocks earlier. With `sec_sel` at 1, it carries the selected and muted data two clocks after input, with no memory delay.
- R9: `pri_out` carries the same data stream as the secondary copy, but 2*FRAME_BITS clocks later. Before the delay memory has filled after reset, it reads 0.
- R10: During reset, `pri_out` and `sec_out` are 0, `err_flag` is 1, `lock_ind` is 0 and `xtal_sel` is 1. The auxiliary stream is the current source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_stb | input | 1 | High on the first bit of each frame |
| rx_bit | input | 1 | Demodulated receiver data bit |
| aux_bit | input | 1 | Auxiliary serial data bit |
| rx_valid | input | 1 | Validity flag from the receiver |
| pll_lock | input | 1 | Asynchronous PLL lock status |
| force_aux | input | 1 | Force selection of the auxiliary stream |
| mute_code | input | 2 | Forced-mute command, nonzero mutes |
| sec_sel | input | 1 | 0: secondary pin carries validity, 1: data copy |
| pri_out | output | 1 | Primary data output, two-frame latency |
| sec_out | output | 1 | Secondary pin: validity flag or undelayed data copy |
| err_flag | output | 1 | High unless receiver data is passing |
| lock_ind | output | 1 | Lock-state indication |
| xtal_sel | output | 1 | Steers clock source to the crystal when high |

## Verification
A lock change reaches the controller after two synchronizer clocks. The controller then acts at the next frame strobe, so the bench changes commands at bit 10 of a frame and expects the effect from the next frame. The status flags move on that strobe edge, and the bench samples them mid-frame on the falling clock edge, well clear of both frame ends. Secondary data lags its input by exactly two clocks and primary data by two frames plus two clocks. The bench therefore rebuilds each output frame from samples taken at those fixed offsets and classifies it as receiver, auxiliary, zero or mixed. Validity routing is checked bit by bit against the value driven two clocks earlier.

// File: rtl/asel_pkg.sv
`timescale 1ns/1ps
package asel_pkg;
  typedef enum logic {SRC_RX = 1'b0, SRC_AUX = 1'b1} src_e;
  typedef enum logic {PH_PASS = 1'b0, PH_GAP = 1'b1} phase_e;

  localparam logic [1:0] MUTE_NONE = 2'b00;

  function automatic logic mute_requested(input logic [1:0] code);
    return code != MUTE_NONE;
  endfunction
endpackage

// File: rtl/asel_sync.sv
`timescale 1ns/1ps
// Multi-flop synchronizer for the asynchronous lock status.
module asel_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '0;
    else     chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/asel_ctrl.sv
`timescale 1ns/1ps
// Source selection state machine; all decisions taken on frame strobes.
module asel_ctrl
  import asel_pkg::*;
#(
  parameter int GAP_FRAMES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_stb,
  input  logic       lock_s,
  input  logic       force_aux,
  input  logic [1:0] mute_code,
  output src_e       src_o,
  output logic       gap_o,
  output logic       fmute_o,
  output logic       err_o,
  output logic       lock_ind_o,
  output logic       xtal_o
);
  localparam int CW = (GAP_FRAMES > 2) ? $clog2(GAP_FRAMES) : 1;
  localparam logic [CW-1:0] RELOAD = CW'((GAP_FRAMES > 0) ? GAP_FRAMES - 1 : 0);

  phase_e        phase_q, phase_n;
  src_e          cur_q, cur_n;
  src_e          tgt_q, tgt_n;
  src_e          want;
  logic [CW-1:0] rem_q, rem_n;
  logic          fm_q, fm_n;
  logic          err_n, xtal_n, lock_ind_n;

  assign want = (force_aux || !lock_s) ? SRC_AUX : SRC_RX;

  always_comb begin
    phase_n = phase_q;
    cur_n   = cur_q;
    tgt_n   = tgt_q;
    rem_n   = rem_q;
    if (frame_stb) begin
      case (phase_q)
        PH_PASS: begin
          if (want != cur_q) begin
            if (GAP_FRAMES == 0) begin
              cur_n = want;
            end else begin
              phase_n = PH_GAP;
              tgt_n   = want;
              rem_n   = RELOAD;
            end
          end
        end
        default: begin
          if (want != tgt_q) begin
            tgt_n = want;
            rem_n = RELOAD;
          end else if (rem_q == '0) begin
            phase_n = PH_PASS;
            cur_n   = tgt_q;
          end else begin
            rem_n = rem_q - 1'b1;
          end
        end
      endcase
    end
    fm_n       = frame_stb ? mute_requested(mute_code) : fm_q;
    err_n      = !((phase_n == PH_PASS) && (cur_n == SRC_RX));
    xtal_n     = ((phase_n == PH_PASS) ? cur_n : tgt_n) == SRC_AUX;
    lock_ind_n = lock_s && !force_aux;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q    <= PH_PASS;
      cur_q      <= SRC_AUX;
      tgt_q      <= SRC_AUX;
      rem_q      <= '0;
      fm_q       <= 1'b0;
      err_o      <= 1'b1;
      xtal_o     <= 1'b1;
      lock_ind_o <= 1'b0;
    end else begin
      phase_q    <= phase_n;
      cur_q      <= cur_n;
      tgt_q      <= tgt_n;
      rem_q      <= rem_n;
      fm_q       <= fm_n;
      err_o      <= err_n;
      xtal_o     <= xtal_n;
      lock_ind_o <= lock_ind_n;
    end
  end

  assign src_o   = cur_q;
  assign gap_o   = (phase_q == PH_GAP);
  assign fmute_o = fm_q;
endmodule

// File: rtl/asel_delay.sv
`timescale 1ns/1ps
// Fixed-length delay line in a circular RAM; output gated until filled.
module asel_delay #(
  parameter int DEPTH = 128
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int FW = $clog2(DEPTH + 1);

  logic          mem [DEPTH];
  logic [AW-1:0] ptr;
  logic [FW-1:0] fill;
  logic          rd_q;
  logic          primed_q;

  always_ff @(posedge clk) begin
    rd_q     <= mem[ptr];
    mem[ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr      <= '0;
      fill     <= '0;
      primed_q <= 1'b0;
    end else begin
      ptr      <= (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
      if (fill != FW'(DEPTH)) fill <= fill + 1'b1;
      primed_q <= (fill == FW'(DEPTH));
    end
  end

  assign dout = rd_q & primed_q;
endmodule

// File: rtl/audio_src_sel.sv
`timescale 1ns/1ps
module audio_src_sel
  import asel_pkg::*;
#(
  parameter int FRAME_BITS  = 64,
  parameter int GAP_FRAMES  = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       frame_stb,
  input  logic       rx_bit,
  input  logic       aux_bit,
  input  logic       rx_valid,
  input  logic       pll_lock,
  input  logic       force_aux,
  input  logic [1:0] mute_code,
  input  logic       sec_sel,
  output logic       pri_out,
  output logic       sec_out,
  output logic       err_flag,
  output logic       lock_ind,
  output logic       xtal_sel
);
  localparam int DLY_DEPTH = 2 * FRAME_BITS;

  logic lock_s;
  src_e src;
  logic gap, fmute, silent;
  logic rx_d1, aux_d1, val_d1, sel_d1;
  logic bit_m;
  logic sec_q;

  asel_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pll_lock),
    .q   (lock_s)
  );

  asel_ctrl #(.GAP_FRAMES(GAP_FRAMES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .frame_stb  (frame_stb),
    .lock_s     (lock_s),
    .force_aux  (force_aux),
    .mute_code  (mute_code),
    .src_o      (src),
    .gap_o      (gap),
    .fmute_o    (fmute),
    .err_o      (err_flag),
    .lock_ind_o (lock_ind),
    .xtal_o     (xtal_sel)
  );

  // Input stage aligns data with the state chosen at the same strobe.
  always_ff @(posedge clk) begin
    if (rst) begin
      rx_d1  <= 1'b0;
      aux_d1 <= 1'b0;
      val_d1 <= 1'b0;
      sel_d1 <= 1'b0;
    end else begin
      rx_d1  <= rx_bit;
      aux_d1 <= aux_bit;
      val_d1 <= rx_valid;
      sel_d1 <= sec_sel;
    end
  end

  assign silent = gap | fmute;
  assign bit_m  = ((src == SRC_AUX) ? aux_d1 : rx_d1) & ~silent;

  always_ff @(posedge clk) begin
    if (rst) sec_q <= 1'b0;
    else     sec_q <= sel_d1 ? bit_m : val_d1;
  end
  assign sec_out = sec_q;

  asel_delay #(.DEPTH(DLY_DEPTH)) u_dly (
    .clk  (clk),
    .rst  (rst),
    .din  (bit_m),
    .dout (pri_out)
  );
endmodule

// File: rtl/asel_chk.sv
`timescale 1ns/1ps
module asel_chk (
  input logic clk,
  input logic rst,
  input logic frame_stb,
  input logic force_aux,
  input logic rx_valid,
  input logic sec_sel,
  input logic sec_out,
  input logic err_flag,
  input logic xtal_sel,
  input logic lock_ind,
  input logic silent,
  input logic gap,
  input logic sel_d1
);
  logic [1:0] age;
  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  assert_err_on_strobe_R4: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(err_flag));

  assert_xtal_on_strobe_R5: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(xtal_sel));

  assert_force_drops_lock_R5: assert property (@(posedge clk) disable iff (rst)
    force_aux |=> !lock_ind);

  assert_gap_whole_frames_R3: assert property (@(posedge clk) disable iff (rst)
    !frame_stb |=> $stable(gap));

  assert_mute_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (silent && sel_d1) |=> !sec_out);

  assert_valid_route_R8: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3 && !$past(sec_sel, 2)) |-> (sec_out == $past(rx_valid, 2)));
endmodule

bind audio_src_sel asel_chk i_chk (
  .clk       (clk),
  .rst       (rst),
  .frame_stb (frame_stb),
  .force_aux (force_aux),
  .rx_valid  (rx_valid),
  .sec_sel   (sec_sel),
  .sec_out   (sec_out),
  .err_flag  (err_flag),
  .xtal_sel  (xtal_sel),
  .lock_ind  (lock_ind),
  .silent    (silent),
  .gap       (gap),
  .sel_d1    (sel_d1)
);

// File: tb/test_audio_src_sel.sv
`timescale 1ns/1ps
module test_audio_src_sel;
  localparam int FB = 64;
  localparam int D  = 2 * FB;
  localparam logic [FB-1:0] RXP  = 64'hF0E1_D2C3_B4A5_9687;
  localparam logic [FB-1:0] AUXP = 64'h1357_9BDF_2468_ACE0;
  localparam int C_ZERO = 0, C_RX = 1, C_AUX = 2, C_MIX = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic frame_stb = 1'b0, rx_bit = 1'b0, aux_bit = 1'b0, rx_valid = 1'b0;
  logic pll_lock = 1'b0, force_aux = 1'b0, sec_sel = 1'b0;
  logic [1:0] mute_code = 2'b00;
  logic pri_out, sec_out, err_flag, lock_ind, xtal_sel;

  int errors = 0, checks = 0;
  int t = 0;
  logic go = 1'b0;
  logic [FB-1:0] sec_w, pri_w;
  int sec_cls [64];
  int pri_cls [64];

  always #10 clk = ~clk;

  audio_src_sel i_audio_src_sel (
    .clk(clk), .rst(rst), .frame_stb(frame_stb), .rx_bit(rx_bit),
    .aux_bit(aux_bit), .rx_valid(rx_valid), .pll_lock(pll_lock),
    .force_aux(force_aux), .mute_code(mute_code), .sec_sel(sec_sel),
    .pri_out(pri_out), .sec_out(sec_out), .err_flag(err_flag),
    .lock_ind(lock_ind), .xtal_sel(xtal_sel)
  );

  function automatic int classify(input logic [FB-1:0] w);
    if (w == RXP)  return C_RX;
    if (w == AUXP) return C_AUX;
    if (w == '0)   return C_ZERO;
    return C_MIX;
  endfunction

  // Sample outputs, then drive the next bit; both on the falling edge.
  always @(negedge clk) begin
    if (go) begin
      int ts, tp;
      ts = t - 2;
      tp = t - 2 - D;
      if (ts >= 0 && ts / FB < 64) begin
        sec_w[ts % FB] = sec_out;
        if (ts % FB == FB - 1) sec_cls[ts / FB] = classify(sec_w);
      end
      if (tp >= 0 && tp / FB < 64) begin
        pri_w[tp % FB] = pri_out;
        if (tp % FB == FB - 1) pri_cls[tp / FB] = classify(pri_w);
      end
      frame_stb = (t % FB == 0);
      rx_bit    = RXP[t % FB];
      aux_bit   = AUXP[t % FB];
      t = t + 1;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Wait until bit b of frame f has just been driven.
  task automatic at_bit(input int f, input int b);
    while (t < f * FB + b + 1) @(posedge clk);
  endtask

  task automatic sample_mid(input int f);
    at_bit(f, 32);
    @(negedge clk);
  endtask

  task automatic expect_frames(input int lo, input int hi, input int cls, input string req);
    while (t < (hi + 3) * FB + 3) @(posedge clk);
    for (int f = lo; f <= hi; f++) begin
      chk(sec_cls[f] == cls, req, $sformatf("sec frame %0d class", f), sec_cls[f], cls);
      chk(pri_cls[f] == cls, "R9", $sformatf("pri frame %0d class", f), pri_cls[f], cls);
    end
  endtask

  task automatic t_reset;
    repeat (4) @(negedge clk);
    chk(pri_out == 1'b0, "R10", "pri_out in reset", pri_out, 0);
    chk(sec_out == 1'b0, "R10", "sec_out in reset", sec_out, 0);
    chk(err_flag == 1'b1, "R10", "err_flag in reset", err_flag, 1);
    chk(lock_ind == 1'b0, "R10", "lock_ind in reset", lock_ind, 0);
    chk(xtal_sel == 1'b1, "R10", "xtal_sel in reset", xtal_sel, 1);
    sec_sel = 1'b1;
    @(posedge clk);
    rst <= 1'b0;
    go  <= 1'b1;
  endtask

  task automatic t_startup_aux;
    at_bit(1, 5);
    @(negedge clk);
    chk(pri_out == 1'b0, "R9", "pri_out before fill", pri_out, 0);
    sample_mid(2);
    chk(err_flag == 1'b1, "R4", "err_flag unlocked", err_flag, 1);
    chk(xtal_sel == 1'b1, "R5", "xtal_sel unlocked", xtal_sel, 1);
    expect_frames(0, 2, C_AUX, "R1");
  endtask

  task automatic t_lock_in;
    at_bit(6, 10);
    pll_lock <= 1'b1;
    at_bit(6, 20);
    @(negedge clk);
    chk(lock_ind == 1'b1, "R5", "lock_ind after lock", lock_ind, 1);
    chk(err_flag == 1'b1, "R4", "err_flag before strobe", err_flag, 1);
    sample_mid(7);
    chk(xtal_sel == 1'b0, "R5", "xtal_sel toward rx", xtal_sel, 0);
    sample_mid(8);
    chk(err_flag == 1'b1, "R4", "err_flag in gap", err_flag, 1);
    sample_mid(9);
    chk(err_flag == 1'b0, "R4", "err_flag rx passing", err_flag, 0);
    expect_frames(7, 8, C_ZERO, "R3");
    expect_frames(9, 9, C_RX, "R1");
  endtask

  task automatic t_force;
    at_bit(13, 10);
    force_aux <= 1'b1;
    at_bit(13, 20);
    @(negedge clk);
    chk(lock_ind == 1'b0, "R5", "lock_ind under force", lock_ind, 0);
    chk(err_flag == 1'b0, "R4", "err_flag waits strobe", err_flag, 0);
    sample_mid(14);
    chk(err_flag == 1'b1, "R2", "err_flag forced", err_flag, 1);
    chk(xtal_sel == 1'b1, "R2", "xtal_sel forced", xtal_sel, 1);
    expect_frames(14, 15, C_ZERO, "R3");
    expect_frames(16, 16, C_AUX, "R2");
  endtask

  task automatic t_release;
    at_bit(20, 10);
    force_aux <= 1'b0;
    sample_mid(21);
    chk(xtal_sel == 1'b0, "R5", "xtal_sel after release", xtal_sel, 0);
    expect_frames(21, 22, C_ZERO, "R3");
    expect_frames(23, 23, C_RX, "R1");
  endtask

  task automatic t_mute_codes;
    at_bit(27, 10); mute_code <= 2'b01;
    at_bit(28, 10); mute_code <= 2'b11;
    at_bit(29, 10); mute_code <= 2'b10;
    at_bit(30, 10); mute_code <= 2'b00;
    expect_frames(28, 30, C_ZERO, "R6");
    expect_frames(31, 31, C_RX, "R6");
  endtask

  task automatic t_mute_priority;
    at_bit(35, 10);
    mute_code <= 2'b01;
    pll_lock  <= 1'b0;
    sample_mid(37);
    chk(xtal_sel == 1'b1, "R5", "xtal_sel toward aux", xtal_sel, 1);
    at_bit(38, 10);
    mute_code <= 2'b00;
    sample_mid(39);
    chk(err_flag == 1'b1, "R4", "err_flag on aux", err_flag, 1);
    expect_frames(36, 38, C_ZERO, "R6");
    expect_frames(39, 39, C_AUX, "R1");
  endtask

  task automatic t_validity;
    logic [39:0] pat;
    pat = 40'hB3_6C_D1_9A_4E;
    at_bit(43, 1);
    sec_sel <= 1'b0;
    @(posedge clk);
    for (int k = 0; k < 40; k++) begin
      @(posedge clk);
      rx_valid <= pat[k];
      @(negedge clk);
      if (k >= 2)
        chk(sec_out == pat[k-2], "R8", $sformatf("validity bit %0d", k), sec_out, pat[k-2]);
    end
    @(posedge clk);
    sec_sel <= 1'b1;
    expect_frames(44, 44, C_AUX, "R8");
  endtask

  task automatic t_whole_frames;
    int mixed;
    mixed = 0;
    for (int f = 0; f <= 42; f++)
      if (sec_cls[f] == C_MIX || pri_cls[f] == C_MIX) mixed++;
    chk(mixed == 0, "R7", "mixed frames seen", mixed, 0);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      sec_cls[i] = -1;
      pri_cls[i] = -1;
    end
    t_reset();
    t_startup_aux();
    t_lock_in();
    t_force();
    t_release();
    t_mute_codes();
    t_mute_priority();
    t_validity();
    t_whole_frames();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule